// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the processor-facing register front end of a tile-based video engine. The host selects one of eight byte-wide registers with a 3-bit select and makes one access per request. The block keeps the state the host programs: a control byte, a mask byte, a 15-bit staging address, a 15-bit live video address, a 3-bit horizontal fine scroll and a single toggle that is shared by the scroll and address registers. The rendering pipeline reads this state from dedicated outputs.

The block holds the 256-byte sprite attribute store and the 32-byte colour palette. Pattern and nametable memory are outside the block. The host reaches them through the data-port register, which the block turns into requests on a simple external request/acknowledge interface. While such a request is outstanding, the host's `cpu_ready` stays low. Pattern reads go through a one-byte read buffer. Palette entries that are mirrored alias onto their base entries.

Top module: `vid_regif`

## Requirements
- R1: After synchronous reset, every value below reads as zero: control, mask, staging address, live address, fine scroll, toggle, read buffer and open-bus latch. This means a read of select 0 returns 0x00 and the first pattern data-port read returns 0x00.
- R2: A write to select 0 (control) stores the byte. It also copies byte bits 1:0 into staging-address bits 11:10.
- R3: A write to select 5 (scroll) with the toggle clear does three things: it sets fine scroll to byte bits 2:0, sets staging bits 4:0 to byte bits 7:3, and sets the toggle. With the toggle set, it sets staging bits 14:12 to byte bits 2:0 and staging bits 9:5 to byte bits 7:3, then clears the toggle. The live address does not change.
- R4: A write to select 6 (address) with the toggle clear sets staging bits 13:8 to byte bits 5:0, clears staging bit 14 and sets the toggle. With the toggle set, it replaces staging bits 7:0, loads the whole staging address into the live address, and clears the toggle.
- R5: A read of select 2 (status) returns {vblank flag, status_lo[6:0]}. It then clears the vblank flag and the toggle.
- R6: Each completed access to select 7 (data port) uses live-address bits 13:0 as the target. Afterwards the live address (15 bits) advances by 32 if control bit 2 is set, and by 1 otherwise.
- R7: A data-port read with a target below 0x2000 returns the byte held in the read buffer. It then refills the buffer with the external byte fetched from that target.
- R8: A data-port read with a target in 0x2000..0x3EFF returns the external byte directly. A target at or above 0x3F00 accesses the internal palette at index target bits 4:0, with no external request.
- R9: Palette indices 0x10, 0x14, 0x18 and 0x1C alias to 0x00, 0x04, 0x08 and 0x0C for both reads and writes. Index 0x11 does not alias.
- R10: A write to select 3 sets the sprite pointer. A write to select 4 stores the byte at the pointer and then increments the pointer, wrapping from 0xFF to 0x00. A read of select 4 returns the byte at the pointer and leaves the pointer unchanged.
- R11: A read of select 0, 1, 3, 5 or 6 returns the open-bus latch. Writes to selects 0, 1, 5 and 6 load the latch with the written byte. Every read loads the latch with the byte it returned.
- R12: A data-port access with a target below 0x3F00 raises `mem_req` and holds `cpu_ready` low until `mem_ack`. No register changes before then.
- R13: A `vblank_set` pulse sets the vblank flag. If it coincides with a status read, the set takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Host access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | 3 | Register select |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes in this cycle |
| vblank_set | input | 1 | Pulse that sets the vblank flag |
| status_lo | input | 7 | Low status bits supplied by the renderer |
| ctrl_out | output | 8 | Control byte |
| mask_out | output | 8 | Mask byte |
| tmp_addr | output | 15 | Staging address |
| cur_addr | output | 15 | Live video address |
| fine_x | output | 3 | Horizontal fine scroll |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | External write enable |
| mem_addr | output | 14 | External target address |
| mem_wdata | output | 8 | External write byte |
| mem_rdata | input | 8 | External read byte, valid with `mem_ack` |
| mem_ack | input | 1 | External access completes |

## Verification
The bench builds the block with its default parameters: a 256-entry sprite store, a 32-entry palette and a wide step of 32. With the full 8-bit sprite pointer, the bench can write at 0xFF and then wrap to 0x00. The 32-entry palette exposes all four aliased indices next to a non-aliased neighbour. The step of 32 lets a single access move the live address from one palette row to the next, and a read at 0x3FFF carries the live address into bit 14 while the following access is masked back to target 0x0000. An external model acknowledges only after several cycles, so the stall, the buffered pattern read and the direct nametable read are all seen with `cpu_ready` held low.

// File: rtl/vid_regif_pkg.sv
package vid_regif_pkg;

    localparam int VADDR_W = 15;
    localparam int TARGET_W = 14;

    typedef enum logic [2:0] {
        SEL_CTRL     = 3'd0,
        SEL_MASK     = 3'd1,
        SEL_STATUS   = 3'd2,
        SEL_SPR_PTR  = 3'd3,
        SEL_SPR_DATA = 3'd4,
        SEL_SCROLL   = 3'd5,
        SEL_VADDR    = 3'd6,
        SEL_VDATA    = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        RGN_PATTERN = 2'd0,
        RGN_NAMETBL = 2'd1,
        RGN_PALETTE = 2'd2
    } region_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_scroll;
        logic wr_vaddr;
        logic rd_status;
        logic dport_done;
    } addr_cmd_t;

    function automatic region_e target_region(input logic [TARGET_W-1:0] t);
        if (t[13:8] == 6'h3F)
            return RGN_PALETTE;
        else if (!t[13])
            return RGN_PATTERN;
        else
            return RGN_NAMETBL;
    endfunction

endpackage

// File: rtl/vid_regif_addr.sv
module vid_regif_addr
    import vid_regif_pkg::*;
#(
    parameter int WIDE_STEP = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  addr_cmd_t          cmd,
    input  logic [7:0]         wdata,
    output logic [7:0]         ctrl_q,
    output logic [VADDR_W-1:0] tmp_q,
    output logic [VADDR_W-1:0] cur_q,
    output logic [2:0]         fine_x_q,
    output logic               toggle_q
);

    localparam logic [VADDR_W-1:0] STEP_WIDE = VADDR_W'(WIDE_STEP);
    localparam logic [VADDR_W-1:0] STEP_ONE  = VADDR_W'(1);

    logic [VADDR_W-1:0] step;
    assign step = ctrl_q[2] ? STEP_WIDE : STEP_ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            tmp_q    <= '0;
            cur_q    <= '0;
            fine_x_q <= '0;
            toggle_q <= 1'b0;
        end else begin
            if (cmd.wr_ctrl) begin
                ctrl_q       <= wdata;
                tmp_q[11:10] <= wdata[1:0];
            end
            if (cmd.wr_scroll) begin
                if (!toggle_q) begin
                    fine_x_q   <= wdata[2:0];
                    tmp_q[4:0] <= wdata[7:3];
                    toggle_q   <= 1'b1;
                end else begin
                    tmp_q[14:12] <= wdata[2:0];
                    tmp_q[9:5]   <= wdata[7:3];
                    toggle_q     <= 1'b0;
                end
            end
            if (cmd.wr_vaddr) begin
                if (!toggle_q) begin
                    tmp_q[13:8] <= wdata[5:0];
                    tmp_q[14]   <= 1'b0;
                    toggle_q    <= 1'b1;
                end else begin
                    tmp_q[7:0] <= wdata;
                    cur_q      <= {tmp_q[14:8], wdata};
                    toggle_q   <= 1'b0;
                end
            end
            if (cmd.rd_status)
                toggle_q <= 1'b0;
            if (cmd.dport_done)
                cur_q <= cur_q + step;
        end
    end

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_scroll || cmd.wr_vaddr) |=> (toggle_q != $past(toggle_q))); // R3

    AST_STAGE_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_vaddr && !toggle_q) |=> (tmp_q[14] == 1'b0)); // R4

    AST_LIVE_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd.dport_done && $past(!rst)) |=>
            (cur_q == $past(cur_q) + ($past(ctrl_q[2]) ? STEP_WIDE : STEP_ONE))); // R6

    AST_SCROLL_KEEPS_LIVE: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_scroll && !cmd.dport_done) |=> $stable(cur_q)); // R3

endmodule

// File: rtl/vid_regif_spr.sv
module vid_regif_spr #(
    parameter int DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ptr,
    input  logic       wr_data,
    input  logic [7:0] wdata,
    output logic [7:0] rd_byte
);

    localparam int AW = $clog2(DEPTH);

    logic [7:0]    store [DEPTH];
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++)
                store[i] <= 8'h00;
        end else begin
            if (wr_ptr)
                ptr_q <= wdata[AW-1:0];
            else if (wr_data) begin
                store[ptr_q] <= wdata;
                ptr_q        <= ptr_q + 1'b1;
            end
        end
    end

    assign rd_byte = store[ptr_q];

    AST_SPR_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_ptr && !wr_data) |=> $stable(ptr_q)); // R10

    AST_SPR_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !wr_ptr) |=> (ptr_q == AW'($past(ptr_q) + 1'b1))); // R10

endmodule

// File: rtl/vid_regif_pal.sv
module vid_regif_pal #(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata
);

    localparam int IW = $clog2(DEPTH);

    logic [7:0]    entry [DEPTH];
    logic [IW-1:0] folded;

    always_comb begin
        folded = idx;
        if (idx[1:0] == 2'b00)
            folded[IW-1] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                entry[i] <= 8'h00;
        end else if (we) begin
            entry[folded] <= wdata;
        end
    end

    assign rdata = entry[folded];

    AST_PAL_FOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (idx[1:0] == 2'b00) |-> (folded < IW'(DEPTH / 2))); // R9

endmodule

// File: rtl/vid_regif.sv
module vid_regif
    import vid_regif_pkg::*;
#(
    parameter int SPR_DEPTH = 256,
    parameter int PAL_DEPTH = 32,
    parameter int WIDE_STEP = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cpu_req,
    input  logic         cpu_we,
    input  logic [2:0]   cpu_sel,
    input  logic [7:0]   cpu_wdata,
    output logic [7:0]   cpu_rdata,
    output logic         cpu_ready,
    input  logic         vblank_set,
    input  logic [6:0]   status_lo,
    output logic [7:0]   ctrl_out,
    output logic [7:0]   mask_out,
    output logic [14:0]  tmp_addr,
    output logic [14:0]  cur_addr,
    output logic [2:0]   fine_x,
    output logic         mem_req,
    output logic         mem_we,
    output logic [13:0]  mem_addr,
    output logic [7:0]   mem_wdata,
    input  logic [7:0]   mem_rdata,
    input  logic         mem_ack
);

    localparam int PAL_IW = $clog2(PAL_DEPTH);

    reg_sel_e              sel;
    logic [TARGET_W-1:0]   target;
    region_e               rgn;
    logic                  is_dport, is_ext, done, rd_done, wr_done;
    addr_cmd_t             cmd;
    logic [VADDR_W-1:0]    cur_q;
    logic                  toggle_q;
    logic [7:0]            mask_q, buf_q, obus_q, rdata_c;
    logic                  vbl_q;
    logic [7:0]            spr_byte, pal_byte;

    assign sel      = reg_sel_e'(cpu_sel);
    assign target   = cur_q[TARGET_W-1:0];
    assign rgn      = target_region(target);
    assign is_dport = (sel == SEL_VDATA);
    assign is_ext   = is_dport && (rgn != RGN_PALETTE);

    assign cpu_ready = is_ext ? mem_ack : 1'b1;
    assign done      = cpu_req && cpu_ready;
    assign rd_done   = done && !cpu_we;
    assign wr_done   = done && cpu_we;

    assign mem_req   = cpu_req && is_ext;
    assign mem_we    = cpu_we;
    assign mem_addr  = target;
    assign mem_wdata = cpu_wdata;

    assign cmd.wr_ctrl    = wr_done && (sel == SEL_CTRL);
    assign cmd.wr_scroll  = wr_done && (sel == SEL_SCROLL);
    assign cmd.wr_vaddr   = wr_done && (sel == SEL_VADDR);
    assign cmd.rd_status  = rd_done && (sel == SEL_STATUS);
    assign cmd.dport_done = done && is_dport;

    vid_regif_addr #(.WIDE_STEP(WIDE_STEP)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wdata    (cpu_wdata),
        .ctrl_q   (ctrl_out),
        .tmp_q    (tmp_addr),
        .cur_q    (cur_q),
        .fine_x_q (fine_x),
        .toggle_q (toggle_q)
    );

    vid_regif_spr #(.DEPTH(SPR_DEPTH)) u_spr (
        .clk     (clk),
        .rst     (rst),
        .wr_ptr  (wr_done && (sel == SEL_SPR_PTR)),
        .wr_data (wr_done && (sel == SEL_SPR_DATA)),
        .wdata   (cpu_wdata),
        .rd_byte (spr_byte)
    );

    vid_regif_pal #(.DEPTH(PAL_DEPTH)) u_pal (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_done && is_dport && (rgn == RGN_PALETTE)),
        .idx   (target[PAL_IW-1:0]),
        .wdata (cpu_wdata),
        .rdata (pal_byte)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS:   rdata_c = {vbl_q, status_lo};
            SEL_SPR_DATA: rdata_c = spr_byte;
            SEL_VDATA: begin
                unique case (rgn)
                    RGN_PALETTE: rdata_c = pal_byte;
                    RGN_PATTERN: rdata_c = buf_q;
                    default:     rdata_c = mem_rdata;
                endcase
            end
            default:      rdata_c = obus_q;
        endcase
    end

    assign cpu_rdata = rdata_c;
    assign cur_addr  = cur_q;
    assign mask_out  = mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            buf_q  <= '0;
            obus_q <= '0;
            vbl_q  <= 1'b0;
        end else begin
            if (wr_done && (sel == SEL_MASK))
                mask_q <= cpu_wdata;
            if (rd_done && is_dport && (rgn == RGN_PATTERN))
                buf_q <= mem_rdata;
            if (vblank_set)
                vbl_q <= 1'b1;
            else if (cmd.rd_status)
                vbl_q <= 1'b0;
            if (rd_done)
                obus_q <= rdata_c;
            else if (wr_done && (sel inside {SEL_CTRL, SEL_MASK, SEL_SCROLL, SEL_VADDR}))
                obus_q <= cpu_wdata;
        end
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> ($stable(cur_q) && $stable(buf_q) && $stable(obus_q))); // R12

    AST_STATUS_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd_status && !vblank_set) |=> (!vbl_q && !toggle_q)); // R5

    AST_VBLANK_WINS: assert property (@(posedge clk) disable iff (rst)
        vblank_set |=> vbl_q); // R13

    AST_PALETTE_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && is_dport && (rgn == RGN_PALETTE)) |-> (!mem_req && cpu_ready)); // R8

endmodule

// File: tb/sim_vid_regif.sv
module sim_vid_regif;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 24;

    typedef struct packed {
        logic       we;
        logic [2:0] sel;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] tag;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 8'h00, 1'b1, 8'h00, 4'd1},   // R1 latch clear
        '{1'b1, 3'd0, 8'h03, 1'b0, 8'h00, 4'd11},
        '{1'b0, 3'd0, 8'h00, 1'b1, 8'h03, 4'd11},  // R11 ctrl write loads latch
        '{1'b1, 3'd1, 8'h5A, 1'b0, 8'h00, 4'd11},
        '{1'b0, 3'd1, 8'h00, 1'b1, 8'h5A, 4'd11},  // R11
        '{1'b1, 3'd3, 8'h10, 1'b0, 8'h00, 4'd11},
        '{1'b0, 3'd3, 8'h00, 1'b1, 8'h5A, 4'd11},  // R11 pointer write leaves latch
        '{1'b1, 3'd4, 8'hC3, 1'b0, 8'h00, 4'd10},
        '{1'b1, 3'd4, 8'h3C, 1'b0, 8'h00, 4'd10},
        '{1'b1, 3'd3, 8'h10, 1'b0, 8'h00, 4'd10},
        '{1'b0, 3'd4, 8'h00, 1'b1, 8'hC3, 4'd10},  // R10
        '{1'b0, 3'd4, 8'h00, 1'b1, 8'hC3, 4'd10},  // R10 read does not step
        '{1'b0, 3'd5, 8'h00, 1'b1, 8'hC3, 4'd11},  // R11 read loads latch
        '{1'b1, 3'd3, 8'h11, 1'b0, 8'h00, 4'd10},
        '{1'b0, 3'd4, 8'h00, 1'b1, 8'h3C, 4'd10},  // R10 write stepped
        '{1'b1, 3'd3, 8'hFF, 1'b0, 8'h00, 4'd10},
        '{1'b1, 3'd4, 8'h77, 1'b0, 8'h00, 4'd10},
        '{1'b1, 3'd4, 8'h88, 1'b0, 8'h00, 4'd10},
        '{1'b1, 3'd3, 8'h00, 1'b0, 8'h00, 4'd10},
        '{1'b0, 3'd4, 8'h00, 1'b1, 8'h88, 4'd10},  // R10 pointer wrap
        '{1'b1, 3'd3, 8'hFF, 1'b0, 8'h00, 4'd10},
        '{1'b0, 3'd4, 8'h00, 1'b1, 8'h77, 4'd10},  // R10
        '{1'b0, 3'd2, 8'h00, 1'b1, 8'h1F, 4'd5},   // R5 status value
        '{1'b0, 3'd6, 8'h00, 1'b1, 8'h1F, 4'd11}   // R11 latch holds status byte
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_sel = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        vblank_set = 1'b0;
    logic [6:0]  status_lo = 7'h1F;
    logic [7:0]  ctrl_out, mask_out;
    logic [14:0] tmp_addr, cur_addr;
    logic [2:0]  fine_x;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ack;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    logic [1:0]  lat_cnt;
    logic [13:0] last_wa;
    logic [7:0]  last_wd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vid_regif u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .vblank_set(vblank_set), .status_lo(status_lo), .ctrl_out(ctrl_out),
        .mask_out(mask_out), .tmp_addr(tmp_addr), .cur_addr(cur_addr), .fine_x(fine_x),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [7:0] ext_byte(input logic [13:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
    endfunction

    // external memory model: acknowledge after a few cycles
    always @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
            mem_ack <= 1'b0;
            last_wa <= '0;
            last_wd <= '0;
        end else if (mem_req && !mem_ack) begin
            if (lat_cnt == 2'd2) begin
                mem_ack <= 1'b1;
                lat_cnt <= '0;
            end else begin
                lat_cnt <= lat_cnt + 1'b1;
            end
        end else begin
            if (mem_req && mem_ack && mem_we) begin
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
            end
            mem_ack <= 1'b0;
        end
    end

    assign mem_rdata = mem_ack ? ext_byte(mem_addr) : 8'h00;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done_flag) begin
            done_flag = 1'b1;
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    int          last_stalls;
    logic [13:0] stall_addr;
    bit          stall_moved;

    task automatic acc(input logic we, input logic [2:0] sel, input logic [7:0] wd,
                       output logic [7:0] rd);
        logic [14:0] cur0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_sel = sel; cpu_wdata = wd;
        last_stalls = 0;
        stall_moved = 1'b0;
        #1;
        cur0 = cur_addr;
        stall_addr = mem_addr;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
            last_stalls++;
            if (cur_addr !== cur0) stall_moved = 1'b1;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] wd);
        logic [7:0] dummy;
        acc(1'b1, sel, wd, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [7:0] exp);
        logic [7:0] r;
        acc(1'b0, sel, 8'h00, r);
        chk(tag, {8'h00, r}, {8'h00, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        do_reset();

        // R1: reset state at the ports
        chk("R1 ctrl", {8'h00, ctrl_out}, 16'h0000);
        chk("R1 mask", {8'h00, mask_out}, 16'h0000);
        chk("R1 stage", {1'b0, tmp_addr}, 16'h0000);
        chk("R1 live", {1'b0, cur_addr}, 16'h0000);
        chk("R1 finex", {13'h0, fine_x}, 16'h0000);
        chk("R1 memreq", {15'h0, mem_req}, 16'h0000);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            acc(VECS[i].we, VECS[i].sel, VECS[i].wd, r);
            if (VECS[i].chk)
                chk($sformatf("R%0d vec%0d", VECS[i].tag, i), {8'h00, r}, {8'h00, VECS[i].exp});
        end

        // R1 / R7: buffer cleared by reset, then refilled
        do_reset();
        rd_chk("R1 buffer after reset", 3'd7, 8'h00);
        rd_chk("R7 buffered byte", 3'd7, ext_byte(14'h0000));
        chk("R6 live step by one", {1'b0, cur_addr}, 16'h0002);

        // R2
        do_reset();
        wr(3'd0, 8'h02);
        chk("R2 ctrl", {8'h00, ctrl_out}, 16'h0002);
        chk("R2 stage", {1'b0, tmp_addr}, 16'h0800);

        // R3
        wr(3'd5, 8'hAD);
        chk("R3 finex", {13'h0, fine_x}, 16'h0005);
        chk("R3 first stage", {1'b0, tmp_addr}, 16'h0815);
        wr(3'd5, 8'h5E);
        chk("R3 second stage", {1'b0, tmp_addr}, 16'h6975);
        chk("R3 live kept", {1'b0, cur_addr}, 16'h0000);

        // R4
        wr(3'd6, 8'hFF);
        chk("R4 first stage", {1'b0, tmp_addr}, 16'h3F75);
        chk("R4 live kept", {1'b0, cur_addr}, 16'h0000);
        wr(3'd6, 8'h10);
        chk("R4 second stage", {1'b0, tmp_addr}, 16'h3F10);
        chk("R4 live loaded", {1'b0, cur_addr}, 16'h3F10);

        // R8 / R9 palette
        wr(3'd7, 8'h2A);
        chk("R8 palette no stall", last_stalls[15:0], 16'h0000);
        wr(3'd7, 8'h44);
        wr(3'd6, 8'h3F); wr(3'd6, 8'h00);
        rd_chk("R9 alias 0x10 to 0x00", 3'd7, 8'h2A);
        rd_chk("R9 0x11 not aliased", 3'd7, 8'h00);
        wr(3'd6, 8'h3F); wr(3'd6, 8'h04);
        wr(3'd7, 8'h31);
        wr(3'd6, 8'h3F); wr(3'd6, 8'h14);
        rd_chk("R9 read 0x14 from 0x04", 3'd7, 8'h31);
        wr(3'd6, 8'h3F); wr(3'd6, 8'h11);
        rd_chk("R8 palette direct 0x11", 3'd7, 8'h44);

        // R5 toggle clear by status read
        wr(3'd6, 8'h21);
        rd_chk("R5 status", 3'd2, 8'h1F);
        wr(3'd6, 8'h22);
        chk("R5 toggle cleared", {1'b0, tmp_addr}, 16'h2211);
        chk("R5 live kept", {1'b0, cur_addr}, 16'h3F12);
        rd_chk("R5 status again", 3'd2, 8'h1F);

        // R13 vblank
        @(negedge clk); vblank_set = 1'b1;
        @(negedge clk); vblank_set = 1'b0;
        rd_chk("R13 flag set", 3'd2, 8'h9F);
        rd_chk("R5 flag cleared", 3'd2, 8'h1F);
        rd_chk("R11 latch from status", 3'd0, 8'h1F);

        // R6 step size and 14-bit target
        wr(3'd0, 8'h04);
        wr(3'd6, 8'h3F); wr(3'd6, 8'h00);
        acc(1'b0, 3'd7, 8'h00, r);
        chk("R6 wide step", {1'b0, cur_addr}, 16'h3F20);
        wr(3'd0, 8'h00);
        acc(1'b0, 3'd7, 8'h00, r);
        chk("R6 narrow step", {1'b0, cur_addr}, 16'h3F21);
        wr(3'd6, 8'h3F); wr(3'd6, 8'hFF);
        acc(1'b0, 3'd7, 8'h00, r);
        chk("R6 carry into bit 14", {1'b0, cur_addr}, 16'h4000);
        acc(1'b0, 3'd7, 8'h00, r);
        chk("R6 target masked", {2'b00, stall_addr}, 16'h0000);
        chk("R12 stall seen", {15'h0, (last_stalls > 0)}, 16'h0001);
        chk("R12 live frozen while waiting", {15'h0, stall_moved}, 16'h0000);

        // R7 buffered pattern reads
        wr(3'd6, 8'h01); wr(3'd6, 8'h23);
        rd_chk("R7 old buffer returned", 3'd7, ext_byte(14'h0000));
        rd_chk("R7 refilled from 0x0123", 3'd7, ext_byte(14'h0123));

        // R8 nametable direct
        wr(3'd6, 8'h23); wr(3'd6, 8'h45);
        rd_chk("R8 nametable direct", 3'd7, ext_byte(14'h2345));
        chk("R12 nametable stall", {15'h0, (last_stalls > 0)}, 16'h0001);

        // R12 external write
        wr(3'd6, 8'h21); wr(3'd6, 8'h00);
        wr(3'd7, 8'h99);
        chk("R12 write stall", {15'h0, (last_stalls > 0)}, 16'h0001);
        chk("R12 write address", {2'b00, last_wa}, 16'h2100);
        chk("R12 write byte", {8'h00, last_wd}, 16'h0099);
        chk("R6 after write", {1'b0, cur_addr}, 16'h2101);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule